// File: doc/BRIEF.md
# Word-to-Pixel Serializer

This block sits between a word FIFO and a display pixel pipeline. It takes 32-bit memory words over a valid/ready stream and returns one pixel per handshake on a 24-bit output. Each pixel is right-aligned and zero-extended. The pixel width can be 1, 2, 4, 8, 16 or 24 bits. A byte-order control sets where in each word the first pixel is taken from: the least significant end or the most significant end.

A 64-bit residue register holds the bits that have not been consumed yet. Because of it, a 24-bit pixel may take its bits from two consecutive words, and three words give four pixels. A new word is taken only when the bits left after the current pop are fewer than one pixel. Width and order settings are sampled only on a synchronous flush, which also discards the residue. Size codes 6 and 7 act as 24 bits.

Back-pressure rules on both streams:
- A transfer happens on a clock edge where valid and ready are both high.
- While `out_valid` is high and `out_ready` is low, the pixel stays unchanged.
- `in_ready` may depend on `out_ready` in the same cycle.
- While `flush` is high, both `in_ready` and `out_valid` are low.

Top module: `pix_serializer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The active setting is 1-bit pixels in little-endian order until the first flush.
- R2: Size code 0/1/2/3/4/5 selects 1/2/4/8/16/24-bit pixels. Pixel bits above the selected width are zero.
- R3: Little-endian mode (`cfg_big_endian`=0): pixel k holds stream bits k*w to k*w+w-1. Stream bit i is bit i%32 of word i/32. Stream bits map to pixel bits LSB first.
- R4: Big-endian mode (`cfg_big_endian`=1): pixel k holds stream bits k*w to k*w+w-1. Stream bit i is bit 31-(i%32) of word i/32. The first stream bit of a pixel becomes its MSB.
- R5: With 24-bit pixels, three words produce exactly four pixels. Pixels may span word boundaries.
- R6: `in_ready` is high only when the residue bit count, minus the pixel popped this cycle, is below the pixel width. The residue never exceeds 55 bits.
- R7: If no word is offered, `out_valid` drops once the residue is shorter than a pixel. No pixel is lost or duplicated.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_pixel` holds its value on the next cycle.
- R9: `cfg_size` and `cfg_big_endian` are sampled only in a cycle with `flush` high. That cycle empties the residue. Changes made without a flush have no effect.
- R10: With `in_valid` and `out_ready` held high, one pixel is emitted every cycle from the first pixel to the last, for every width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard residue, load the settings |
| cfg_size | input | 3 | Pixel size code |
| cfg_big_endian | input | 1 | 1 = first pixel from the word MSBs |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word accepted this cycle |
| in_word | input | 32 | Memory word |
| out_valid | output | 1 | Pixel available |
| out_ready | input | 1 | Consumer takes the pixel |
| out_pixel | output | 24 | Right-aligned pixel |

## Verification
The two streams behave differently in time:
- **Output side:** `out_valid` and `out_pixel` come straight from registered state, so a pixel is visible in the cycle after the word that completes it was accepted.
- **Input side:** `in_ready` follows the same cycle's `out_ready` through combinational logic.

The bench drives every input at the falling edge and waits 1 ns. In that cycle it evaluates both handshakes before the rising edge that commits them. Each accepted pixel is compared with a bit-stream model. Hold and flush effects are checked one cycle later, again at the falling edge.

// File: rtl/pix_ser_pkg.sv
package pix_ser_pkg;
  localparam int WORD_W = 32;
  localparam int PIX_W  = 24;
  localparam int BUF_W  = 64;
  localparam int CNT_W  = $clog2(BUF_W + 1);
  localparam int WID_W  = $clog2(PIX_W + 1);

  typedef enum logic [2:0] {
    PS_1  = 3'd0,
    PS_2  = 3'd1,
    PS_4  = 3'd2,
    PS_8  = 3'd3,
    PS_16 = 3'd4,
    PS_24 = 3'd5
  } pix_size_e;
endpackage

// File: rtl/pix_width_dec.sv
module pix_width_dec
  import pix_ser_pkg::*;
(
  input  logic [2:0]       size_code,
  output logic [WID_W-1:0] width
);
  always_comb begin
    case (size_code)
      PS_1:    width = WID_W'(1);
      PS_2:    width = WID_W'(2);
      PS_4:    width = WID_W'(4);
      PS_8:    width = WID_W'(8);
      PS_16:   width = WID_W'(16);
      default: width = WID_W'(24);
    endcase
  end
endmodule

// File: rtl/pix_extract.sv
module pix_extract
  import pix_ser_pkg::*;
(
  input  logic [BUF_W-1:0] resid,
  input  logic [WID_W-1:0] width,
  input  logic             big_end,
  output logic [PIX_W-1:0] pixel
);
  logic [PIX_W:0]   mask_w;
  logic [BUF_W-1:0] aligned;
  logic [CNT_W-1:0] top_shift;

  always_comb begin
    mask_w    = (PIX_W+1)'(1) << width;
    mask_w    = mask_w - (PIX_W+1)'(1);
    top_shift = CNT_W'(BUF_W) - CNT_W'(width);
    aligned   = big_end ? (resid >> top_shift) : resid;
    pixel     = aligned[PIX_W-1:0] & mask_w[PIX_W-1:0];
  end
endmodule

// File: rtl/pix_residue.sv
module pix_residue
  import pix_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              big_end,
  input  logic [WID_W-1:0]  width,
  input  logic              pop,
  input  logic              push,
  input  logic [WORD_W-1:0] word,
  output logic [BUF_W-1:0]  resid,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  count_after
);
  logic [BUF_W-1:0] shifted, inserted;
  logic [CNT_W-1:0] pop_bits;

  always_comb begin
    pop_bits    = pop ? CNT_W'(width) : '0;
    count_after = count - pop_bits;
    shifted     = big_end ? (resid << pop_bits) : (resid >> pop_bits);
    if (big_end)
      inserted = {word, {(BUF_W-WORD_W){1'b0}}} >> count_after;
    else
      inserted = {{(BUF_W-WORD_W){1'b0}}, word} << count_after;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      resid <= '0;
      count <= '0;
    end else begin
      resid <= push ? (shifted | inserted) : shifted;
      count <= count_after + (push ? CNT_W'(WORD_W) : '0);
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count < CNT_W'(PIX_W + WORD_W));

  assert_flush_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
  import pix_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [2:0]        cfg_size,
  input  logic              cfg_big_endian,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pixel
);
  logic [2:0]       act_size;
  logic             act_be;
  logic [WID_W-1:0] width;
  logic [BUF_W-1:0] resid;
  logic [CNT_W-1:0] count, count_after;
  logic             pop, push;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_size <= PS_1;
      act_be   <= 1'b0;
    end else if (flush) begin
      act_size <= cfg_size;
      act_be   <= cfg_big_endian;
    end
  end

  pix_width_dec u_wdec (.size_code(act_size), .width(width));

  always_comb begin
    out_valid = !flush && (count >= CNT_W'(width));
    pop       = out_valid && out_ready;
    in_ready  = !flush && (count_after < CNT_W'(width));
    push      = in_valid && in_ready;
  end

  pix_residue u_res (
    .clk(clk), .rst_n(rst_n), .flush(flush), .big_end(act_be),
    .width(width), .pop(pop), .push(push), .word(in_word),
    .resid(resid), .count(count), .count_after(count_after)
  );

  pix_extract u_ext (
    .resid(resid), .width(width), .big_end(act_be), .pixel(out_pixel)
  );

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (flush || (out_valid && $stable(out_pixel))));

  assert_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((32'(out_pixel) >> width) == 32'd0));

  assert_no_push_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (count <= CNT_W'(WORD_W + PIX_W - 1)));
endmodule

// File: tb/pix_serializer_tb.sv
module pix_serializer_tb;
  logic        clk = 0, rst_n = 0, flush = 0;
  logic [2:0]  cfg_size = 0;
  logic        cfg_big_endian = 0;
  logic        in_valid = 0, in_ready;
  logic [31:0] in_word = 0;
  logic        out_valid, out_ready = 0;
  logic [23:0] out_pixel;

  pix_serializer u_dut (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  logic [31:0] wq [3];

  typedef struct packed {
    logic [2:0]  size;
    logic        be;
    logic [31:0] w0, w1, w2;
    logic [23:0] first;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 32'h12345678, 32'h9ABCDEF0, 32'h0F1E2D3C, 24'h0},
    '{3'd0, 1'b1, 32'h92345678, 32'h9ABCDEF0, 32'h0F1E2D3C, 24'h1},
    '{3'd1, 1'b0, 32'h12345677, 32'h9ABCDEF0, 32'h0F1E2D3C, 24'h3},
    '{3'd1, 1'b1, 32'h12345678, 32'h9ABCDEF0, 32'h0F1E2D3C, 24'h0},
    '{3'd2, 1'b0, 32'h12345678, 32'h9ABCDEF0, 32'h0F1E2D3C, 24'h8},
    '{3'd2, 1'b1, 32'h12345678, 32'h9ABCDEF0, 32'h0F1E2D3C, 24'h1},
    '{3'd3, 1'b0, 32'h12345678, 32'h9ABCDEF0, 32'h0F1E2D3C, 24'h78},
    '{3'd3, 1'b1, 32'h12345678, 32'h9ABCDEF0, 32'h0F1E2D3C, 24'h12},
    '{3'd4, 1'b0, 32'h12345678, 32'h9ABCDEF0, 32'h0F1E2D3C, 24'h5678},
    '{3'd4, 1'b1, 32'h12345678, 32'h9ABCDEF0, 32'h0F1E2D3C, 24'h1234},
    '{3'd5, 1'b0, 32'h12345678, 32'h9ABCDEF0, 32'h0F1E2D3C, 24'h345678},
    '{3'd5, 1'b1, 32'h12345678, 32'h9ABCDEF0, 32'h0F1E2D3C, 24'h123456}
  };

  function automatic int wid(input logic [2:0] s);
    case (s)
      3'd0: return 1;  3'd1: return 2;  3'd2: return 4;
      3'd3: return 8;  3'd4: return 16; default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] ref_pix(input logic [2:0] s, input logic be, input int k);
    int w = wid(s);
    logic [23:0] p = '0;
    for (int j = 0; j < w; j++) begin
      int i = k * w + j;
      logic b = be ? wq[i / 32][31 - (i % 32)] : wq[i / 32][i % 32];
      if (be) p[w - 1 - j] = b; else p[j] = b;
    end
    return p;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_flush(input logic [2:0] s, input logic be);
    @(negedge clk);
    in_valid = 0; out_ready = 0;
    cfg_size = s; cfg_big_endian = be; flush = 1;
    @(negedge clk);
    flush = 0;
  endtask

  // mode 0: free run, 1: output back-pressure, 2: input gaps
  task automatic stream(input logic [2:0] s, input logic be, input int nw,
                        input int npix, input int mode, input logic [23:0] first_exp);
    int sent = 0, got = 0, cyc = 0, first_c = -1, last_c = 0;
    logic held = 0;
    logic [23:0] hp = '0;
    string tag = (wid(s) == 24) ? "R5" : (be ? "R4" : "R3");
    while (got < npix && cyc < 2000) begin
      @(negedge clk);
      in_valid  = (sent < nw) && !(mode == 2 && cyc % 4 == 1);
      in_word   = wq[(sent < nw) ? sent : 0];
      out_ready = !(mode == 1 && cyc % 3 != 0);
      #1;
      if (held) begin
        check("R8 hold valid", 32'(out_valid), 32'd1);
        check("R8 hold pixel", 32'(out_pixel), 32'(hp));
        held = 0;
      end
      if (out_valid && out_ready) begin
        if (got == 0) begin
          first_c = cyc;
          check("R2 first pixel", 32'(out_pixel), 32'(first_exp));
        end
        check(tag, 32'(out_pixel), 32'(ref_pix(s, be, got)));
        got++;
        last_c = cyc;
      end else if (out_valid) begin
        held = 1;
        hp = out_pixel;
      end
      if (in_valid && in_ready) sent++;
      cyc++;
    end
    check("R7 pixel count", 32'(got), 32'(npix));
    if (mode == 0 && npix > 1)
      check("R10 one per clock", 32'(last_c - first_c + 1), 32'(npix));
    @(negedge clk);
    in_valid = 0; out_ready = 0;
  endtask

  initial begin
    wait (cycles == 150000);
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    bad++; total++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
  always @(posedge clk) cycles++;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 out_valid", 32'(out_valid), 32'd0);
    check("R1 in_ready", 32'(in_ready), 32'd1);

    // R1: default setting is 1-bit little-endian without any flush
    wq[0] = 32'h00000005; wq[1] = '0; wq[2] = '0;
    stream(3'd0, 1'b0, 1, 32, 0, 24'h1);

    // table walk over sizes, orders and flow patterns
    for (int v = 0; v < NV; v++) begin
      wq[0] = VECS[v].w0; wq[1] = VECS[v].w1; wq[2] = VECS[v].w2;
      do_flush(VECS[v].size, VECS[v].be);
      stream(VECS[v].size, VECS[v].be, 3, 96 / wid(VECS[v].size), v % 3, VECS[v].first);
    end

    // R6: 24-bit, no consumer: one word accepted, then in_ready low
    do_flush(3'd5, 1'b0);
    @(negedge clk);
    in_valid = 1; in_word = 32'h12345678; out_ready = 0;
    #1;
    check("R6 ready when empty", 32'(in_ready), 32'd1);
    @(negedge clk);
    #1;
    check("R6 ready with full pixel", 32'(in_ready), 32'd0);
    check("R6 valid", 32'(out_valid), 32'd1);
    check("R5 pixel", 32'(out_pixel), 32'h345678);
    // R7: one 24-bit pixel taken with no more words: 8 bits left, valid drops
    in_valid = 0; out_ready = 1;
    @(negedge clk);
    #1;
    check("R7 valid low when starved", 32'(out_valid), 32'd0);
    check("R6 ready when short", 32'(in_ready), 32'd1);

    // R9: flush discards residue and loads new setting; later edits ignored
    do_flush(3'd3, 1'b0);
    wq[0] = 32'h12345678;
    stream(3'd3, 1'b0, 1, 1, 0, 24'h78);
    do_flush(3'd4, 1'b0);
    cfg_size = 3'd0; cfg_big_endian = 1'b1;
    wq[0] = 32'h9ABCDEF0;
    stream(3'd4, 1'b0, 1, 2, 0, 24'hDEF0);
    #1;
    check("R9 residue gone", 32'(out_valid), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule